// File: doc/BRIEF.md
# Barrel Shifter Operand Unit

This block builds the second operand of an ALU, together with a shifter carry-out, from an operand descriptor. The descriptor picks one of three operand forms. The first is a rotated immediate made from an 8-bit constant and a 4-bit rotate code. The second is a register value passed through unchanged. The third is a register value shifted by one of four shift kinds. In the shifted form, the shift count comes from a 5-bit immediate field or from the low byte of a second register. A one-bit rotate through the carry flag is also available.

The carry-out is meant to drive the C flag whenever a move or a logical operation updates flags. The result and the carry-out are registered, so both appear one clock after the descriptor is presented. Register file reads and the ALU itself sit outside this block.

Top module: `operand_shifter`

## Requirements
- R1: While `rst_n` is low, `result` and `carry_out` are both 0.
- R2: With `op_form` = 0 (immediate), `result` is `imm8` zero-extended to 32 bits and rotated right by 2 × `rot4`.
- R3: In the immediate form, a `rot4` of 0 gives `carry_out` = `carry_in`. Any other `rot4` gives `carry_out` = bit 31 of the rotated result.
- R4: With `op_form` = 1 (plain register), `result` = `reg_val` and `carry_out` = `carry_in`.
- R5: `op_form` = 2 shifts `reg_val` by `shamt5`, and `op_form` = 3 shifts it by a count read from `cnt_reg`. `shift_kind` selects the shift: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For counts 1 to 31, `carry_out` is the last bit shifted out.
- R6: A register count uses only `cnt_reg[7:0]`, and bits 31:8 have no effect. A count of 0 leaves `result` = `reg_val` and `carry_out` = `carry_in`. The same holds for an immediate count of 0 with any shift kind other than rotate right.
- R7: For a register count of 32 or more, a logical left or logical right shift gives a result of 0. At a count of exactly 32, `carry_out` is `reg_val[0]` for a left shift and `reg_val[31]` for a right shift. Above 32, `carry_out` is 0.
- R8: For a register count of 32 or more, an arithmetic right shift fills every result bit and `carry_out` with `reg_val[31]`.
- R9: A rotate right with a register count uses the count modulo 32. A nonzero multiple of 32 leaves `result` = `reg_val` with `carry_out` = `reg_val[31]`.
- R10: `op_form` = 2 with `shift_kind` = 3 and `shamt5` = 0 rotates right by one bit through the carry. `result` = {`carry_in`, `reg_val[31:1]`} and `carry_out` = `reg_val[0]`.
- R11: `result` and `carry_out` reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_form | input | 2 | 0 = immediate, 1 = register, 2 = shift by immediate count, 3 = shift by register count |
| shift_kind | input | 2 | 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR |
| imm8 | input | 8 | Immediate constant |
| rot4 | input | 4 | Immediate rotate code |
| shamt5 | input | 5 | Immediate shift count |
| reg_val | input | 32 | Register value to be shifted |
| cnt_reg | input | 32 | Register holding the shift count |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Operand value |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Directed vectors cover the count boundaries for each shift kind: 0, 1, 31, 32, 33, counts above 63, and counts whose upper bits of `cnt_reg` are set. These separate the zero-count pass-through, the exactly-32 carry cases, the saturation behaviour and the modulo rule for rotates. Immediates with rotate code 0 and with nonzero codes show whether the carry comes from the flag or from bit 31 of the result. The rotate-through-carry case is run with both carry values. Random descriptors then mix all forms on every clock against a bit-serial reference that shifts one position per step, so any carry tap that is off by one position is exposed.

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   op_form,
  input  logic [1:0]   shift_kind,
  input  logic [7:0]   imm8,
  input  logic [3:0]   rot4,
  input  logic [4:0]   shamt5,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] cnt_reg,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out
);
  localparam int W2 = 2 * W;

  logic [7:0]    cnt;
  logic [W2-1:0] lsl_w, lsr_w, ror_w, imm_w;
  logic signed [W2-1:0] asr_src, asr_w;
  logic [W-1:0]  imm_ext, nxt_res;
  logic [4:0]    rot_amt;
  logic          nxt_c, is_rrx;

  assign cnt     = op_form[0] ? cnt_reg[7:0] : {3'b000, shamt5};
  assign is_rrx  = (op_form == 2'd2) && (shift_kind == 2'd3) && (shamt5 == 5'd0);
  assign imm_ext = {{(W-8){1'b0}}, imm8};
  assign rot_amt = {rot4, 1'b0};

  assign lsl_w   = {{W{1'b0}}, reg_val} << cnt;
  assign lsr_w   = {reg_val, {W{1'b0}}} >> cnt;
  assign asr_src = {reg_val, {W{1'b0}}};
  assign asr_w   = asr_src >>> cnt;
  assign ror_w   = {reg_val, reg_val} >> cnt[4:0];
  assign imm_w   = {imm_ext, imm_ext} >> rot_amt;

  always_comb begin
    nxt_res = reg_val;
    nxt_c   = carry_in;
    if (op_form == 2'd0) begin
      nxt_res = imm_w[W-1:0];
      if (rot4 != 4'd0) nxt_c = imm_w[W-1];
    end else if (op_form != 2'd1) begin
      if (is_rrx) begin
        nxt_res = {carry_in, reg_val[W-1:1]};
        nxt_c   = reg_val[0];
      end else if (cnt != 8'd0) begin
        case (shift_kind)
          2'd0: begin nxt_res = lsl_w[W-1:0];  nxt_c = lsl_w[W];    end
          2'd1: begin nxt_res = lsr_w[W2-1:W]; nxt_c = lsr_w[W-1];  end
          2'd2: begin nxt_res = asr_w[W2-1:W]; nxt_c = asr_w[W-1];  end
          default: begin nxt_res = ror_w[W-1:0]; nxt_c = ror_w[W-1]; end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= nxt_res;
      carry_out <= nxt_c;
    end
  end
endmodule

module operand_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op_form,
  input logic [1:0]  shift_kind,
  input logic [7:0]  imm8,
  input logic [3:0]  rot4,
  input logic [4:0]  shamt5,
  input logic [31:0] reg_val,
  input logic [31:0] cnt_reg,
  input logic        carry_in,
  input logic [31:0] result,
  input logic        carry_out
);
  a_r4_plain_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (op_form == 2'd1) |=> (result == $past(reg_val)) && (carry_out == $past(carry_in)));

  a_r3_imm_norot: assert property (@(posedge clk) disable iff (!rst_n)
    (op_form == 2'd0 && rot4 == 4'd0) |=>
      (result == {24'd0, $past(imm8)}) && (carry_out == $past(carry_in)));

  a_r10_rrx: assert property (@(posedge clk) disable iff (!rst_n)
    (op_form == 2'd2 && shift_kind == 2'd3 && shamt5 == 5'd0) |=>
      (result == {$past(carry_in), $past(reg_val[31:1])}) && (carry_out == $past(reg_val[0])));

  a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (op_form == 2'd3 && cnt_reg[7:0] == 8'd0) |=>
      (result == $past(reg_val)) && (carry_out == $past(carry_in)));

  a_r7_left_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (op_form == 2'd3 && shift_kind == 2'd0 && cnt_reg[7:0] > 8'd32) |=>
      (result == 32'd0) && !carry_out);

  a_r8_asr_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (op_form == 2'd3 && shift_kind == 2'd2 && cnt_reg[7:0] >= 8'd32) |=>
      (result == {32{$past(reg_val[31])}}) && (carry_out == $past(reg_val[31])));
endmodule

bind operand_shifter operand_shifter_chk u_chk (.*);

// File: tb/tb_operand_shifter.sv
module tb_operand_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_form = '0, shift_kind = '0;
  logic [7:0]  imm8 = '0;
  logic [3:0]  rot4 = '0;
  logic [4:0]  shamt5 = '0;
  logic [31:0] reg_val = '0, cnt_reg = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;

  int tests = 0, fails = 0;
  bit pending = 0;
  logic [31:0] exp_res;
  logic        exp_c;
  string       exp_tag;

  always #10 clk = ~clk;

  operand_shifter dut (.*);

  function automatic string tag_of(input logic [1:0] f, input logic [1:0] k,
                                   input logic [4:0] s, input logic [31:0] c);
    int n;
    if (f == 0) return "R2/R3";
    if (f == 1) return "R4";
    if (f == 2 && k == 3 && s == 0) return "R10";
    n = (f == 3) ? int'(c[7:0]) : int'(s);
    if (n == 0) return "R6";
    if (n >= 32 && k < 2) return "R7";
    if (n >= 32 && k == 2) return "R8";
    if (n >= 32) return "R9";
    return "R5";
  endfunction

  task automatic model();
    logic [31:0] v;
    logic c;
    int n;
    v = reg_val;
    c = carry_in;
    if (op_form == 0) begin
      v = {24'd0, imm8};
      for (int i = 0; i < 2 * rot4; i++) v = {v[0], v[31:1]};
      if (rot4 != 0) c = v[31];
    end else if (op_form != 1) begin
      n = (op_form == 3) ? int'(cnt_reg[7:0]) : int'(shamt5);
      if (op_form == 2 && shift_kind == 3 && n == 0) begin
        c = reg_val[0];
        v = {carry_in, reg_val[31:1]};
      end else if (n != 0) begin
        if (shift_kind == 3) begin
          if (n % 32 == 0) c = v[31];
          for (int i = 0; i < n % 32; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
        end else begin
          for (int i = 0; i < n; i++) begin
            case (shift_kind)
              2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
              2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
              default: begin c = v[0]; v = {v[31], v[31:1]}; end
            endcase
          end
        end
      end
    end
    exp_res = v;
    exp_c = c;
    exp_tag = tag_of(op_form, shift_kind, shamt5, cnt_reg);
  endtask

  task automatic check_pending();
    if (pending) begin
      tests++;
      if (result !== exp_res || carry_out !== exp_c) begin
        fails++;
        $display("FAIL %s/R11: result=%h carry=%b expected result=%h carry=%b",
                 exp_tag, result, carry_out, exp_res, exp_c);
      end
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [1:0] k, input logic [7:0] i8,
                       input logic [3:0] r4, input logic [4:0] s5, input logic [31:0] rv,
                       input logic [31:0] cr, input logic ci);
    @(negedge clk);
    check_pending();
    op_form = f; shift_kind = k; imm8 = i8; rot4 = r4; shamt5 = s5;
    reg_val = rv; cnt_reg = cr; carry_in = ci;
    model();
    pending = 1;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    op_form = 2'd1; reg_val = 32'hDEAD_BEEF; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    tests++;
    if (result !== 32'd0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: result=%h carry=%b expected result=0 carry=0", result, carry_out);
    end
    rst_n = 1'b1;

    // R2/R3 immediates
    apply(0, 0, 8'hA5, 4'd0, 0, 0, 0, 1'b1);
    apply(0, 0, 8'hA5, 4'd0, 0, 0, 0, 1'b0);
    apply(0, 0, 8'hFF, 4'd4, 0, 0, 0, 1'b0);
    apply(0, 0, 8'h01, 4'd1, 0, 0, 0, 1'b0);
    apply(0, 0, 8'h02, 4'd1, 0, 0, 0, 1'b1);
    apply(0, 0, 8'h81, 4'd15, 0, 0, 0, 1'b0);
    // R4
    apply(1, 2, 8'h00, 4'd3, 5'd7, 32'h8000_0001, 32'd5, 1'b1);
    // R5 immediate and register counts, each kind
    for (int k = 0; k < 4; k++) begin
      apply(2, k[1:0], 0, 0, 5'd1,  32'hC000_0003, 0, 1'b0);
      apply(2, k[1:0], 0, 0, 5'd31, 32'h8000_0001, 0, 1'b1);
      apply(3, k[1:0], 0, 0, 0, 32'h9234_5679, 32'd4, 1'b0);
      apply(3, k[1:0], 0, 0, 0, 32'h9234_5679, 32'h0000_0000, 1'b1);     // R6
      apply(3, k[1:0], 0, 0, 0, 32'h9234_5679, 32'hFFFF_FF00, 1'b0);     // R6 upper bits ignored
      apply(3, k[1:0], 0, 0, 0, 32'h8000_0001, 32'd32, 1'b0);           // R7/R8/R9
      apply(3, k[1:0], 0, 0, 0, 32'h8000_0001, 32'd33, 1'b1);
      apply(3, k[1:0], 0, 0, 0, 32'h7FFF_FFFE, 32'd200, 1'b1);
      apply(3, k[1:0], 0, 0, 0, 32'h1234_5678, 32'hABCD_0124, 1'b0);     // R6 low byte 0x24
    end
    // R6 immediate zero count non-rotate
    apply(2, 2'd1, 0, 0, 5'd0, 32'hF0F0_0001, 0, 1'b1);
    // R9 rotate multiple of 32 and modulo
    apply(3, 2'd3, 0, 0, 0, 32'h8000_0000, 32'd64, 1'b0);
    apply(3, 2'd3, 0, 0, 0, 32'h0000_0010, 32'd37, 1'b0);
    // R10 both carries
    apply(2, 2'd3, 0, 0, 5'd0, 32'h0000_0003, 0, 1'b1);
    apply(2, 2'd3, 0, 0, 5'd0, 32'hFFFF_FFFE, 0, 1'b0);
    // random traffic, compared every clock
    for (int i = 0; i < 3000; i++) begin
      apply($urandom_range(0, 3), $urandom_range(0, 3), 8'($urandom), 4'($urandom),
            5'($urandom), $urandom, ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 70)),
            1'($urandom));
    end
    @(negedge clk);
    check_pending();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule